// File: doc/BRIEF.md
# Immediate Codec Command Port

This block lets software talk to a codec one verb at a time without any command or response rings. Software loads a 32-bit verb into a command register and then sets a busy flag in a status register. The block offers the held verb on an outbound verb stream and waits for the link to accept it. It then watches the inbound response port for a response from the codec named in the verb's top four bits. That response is latched into a response register, the valid flag is raised and busy drops, all on the same clock edge.

Software reads busy to learn whether a new command may start. It clears a stale valid flag by writing one to it, loads the verb, and sets busy. It then polls valid, or waits for it, and reads the response. Responses that arrive with no command outstanding are dropped. So are responses from a different codec.

Top module: `imm_cmd_if`

## Requirements
- R1: After reset, status reads 0 (busy bit 0 = 0, valid bit 1 = 0), the response register reads 0 and `verb_valid_o` is low.
- R2: While busy is 0, a write to register address 0 stores the verb, and a read of address 0 returns it.
- R3: While busy is 1, writes to the command register are ignored. The stored verb and `verb_data_o` keep their old values.
- R4: Writing status (address 2) with bit 0 = 1 while idle sets busy. It also raises `verb_valid_o` with the held verb one cycle later. The verb is held until `verb_ready_i` is seen, and `verb_valid_o` then drops.
- R5: While a command is outstanding, a response whose `rsp_codec_i` equals verb bits 31:28 is latched into the response register (address 1). On the same edge valid becomes 1 and busy becomes 0.
- R6: A response is discarded and does not set valid in three cases: no command is outstanding (idle), the verb has not yet been accepted, or the codec does not match. The response register is left unchanged.
- R7: Valid is write-one-to-clear: a status write with bit 1 = 1 clears it, and bit 1 = 0 leaves it.
- R8: When a matching response and a valid-clear write happen in the same cycle, the response wins and valid stays 1.
- R9: Software cannot clear busy. A status write with bit 0 = 0, or any status write while busy, leaves busy set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 command, 1 response, 2 status |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i` (combinational) |
| verb_valid_o | output | 1 | Verb offered to the link |
| verb_ready_i | input | 1 | Link accepts the offered verb |
| verb_data_o | output | DATA_W | Verb being sent |
| rsp_valid_i | input | 1 | Response present on the inbound port |
| rsp_codec_i | input | CODEC_W | Codec address of the inbound response |
| rsp_data_i | input | DATA_W | Inbound response data |

## Verification
A sequencer stuck in the send state would show `verb_valid_o` still high one cycle after the handshake. A sequencer stuck waiting would show busy still set, and valid low, on the cycle after a matching response. A bad match on the codec field shows up at once in two ways: valid rises for a foreign or idle-time response, or the response register changes without valid. A command register left writable while busy shows up on the next read of address 0 or on `verb_data_o`.

// File: rtl/imm_cmd_pkg.sv
package imm_cmd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} seq_state_e;
  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_RSP  = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam int STAT_BUSY  = 0;
  localparam int STAT_VALID = 1;
endpackage

// File: rtl/imm_regs.sv
module imm_regs
  import imm_cmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              busy_i,
  input  logic              rsp_take_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic [DATA_W-1:0] cmd_o,
  output logic              valid_o,
  output logic              launch_o
);
  logic [DATA_W-1:0] cmd_q, rsp_q;
  logic              valid_q;
  logic              cmd_we, stat_we, clr_valid;

  assign cmd_we    = reg_wr_i && (reg_addr_i == RA_CMD) && !busy_i;
  assign stat_we   = reg_wr_i && (reg_addr_i == RA_STAT);
  assign launch_o  = stat_we && reg_wdata_i[STAT_BUSY] && !busy_i;
  assign clr_valid = stat_we && reg_wdata_i[STAT_VALID];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      rsp_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (cmd_we) cmd_q <= reg_wdata_i;
      if (rsp_take_i) begin
        rsp_q   <= rsp_data_i;
        valid_q <= 1'b1;        // set beats clear
      end else if (clr_valid) begin
        valid_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_CMD:  reg_rdata_o = cmd_q;
      RA_RSP:  reg_rdata_o = rsp_q;
      RA_STAT: begin
        reg_rdata_o[STAT_BUSY]  = busy_i;
        reg_rdata_o[STAT_VALID] = valid_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign cmd_o   = cmd_q;
  assign valid_o = valid_q;

  // R3: command frozen while busy
  a_r3_cmd_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cmd_q));
  // R7: write-one clears valid when no response competes
  a_r7_w1c_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we && reg_wdata_i[STAT_VALID] && !rsp_take_i) |=> !valid_q);
  // R8: accepted response always leaves valid set
  a_r8_take_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_take_i |=> valid_q);
endmodule

// File: rtl/imm_seq.sv
module imm_seq
  import imm_cmd_pkg::*;
#(
  parameter int CODEC_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic [CODEC_W-1:0] cmd_codec_i,
  input  logic               verb_ready_i,
  input  logic               rsp_valid_i,
  input  logic [CODEC_W-1:0] rsp_codec_i,
  output logic               busy_o,
  output logic               verb_valid_o,
  output logic               rsp_take_o
);
  seq_state_e state_q, state_d;

  assign busy_o       = (state_q != ST_IDLE);
  assign verb_valid_o = (state_q == ST_SEND);
  assign rsp_take_o   = (state_q == ST_WAIT) && rsp_valid_i && (rsp_codec_i == cmd_codec_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (launch_i) state_d = ST_SEND;
      ST_SEND: if (verb_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (rsp_take_o) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R4: verb held until accepted
  a_r4_verb_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verb_valid_o && !verb_ready_i) |=> verb_valid_o);
  // R4: verb offered once
  a_r4_verb_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verb_valid_o && verb_ready_i) |=> !verb_valid_o);
  // R9: busy leaves only through an accepted response
  a_r9_busy_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rsp_take_o) |=> busy_o);
endmodule

// File: rtl/imm_cmd_if.sv
module imm_cmd_if
  import imm_cmd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CODEC_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               verb_valid_o,
  input  logic               verb_ready_i,
  output logic [DATA_W-1:0]  verb_data_o,
  input  logic               rsp_valid_i,
  input  logic [CODEC_W-1:0] rsp_codec_i,
  input  logic [DATA_W-1:0]  rsp_data_i
);
  localparam int CODEC_LSB = DATA_W - CODEC_W;

  logic              busy, valid, launch, rsp_take;
  logic [DATA_W-1:0] cmd;

  imm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .rsp_take_i(rsp_take), .rsp_data_i,
    .cmd_o(cmd), .valid_o(valid), .launch_o(launch)
  );

  imm_seq #(.CODEC_W(CODEC_W)) u_seq (
    .clk_i, .rst_ni, .launch_i(launch),
    .cmd_codec_i(cmd[DATA_W-1:CODEC_LSB]),
    .verb_ready_i, .rsp_valid_i, .rsp_codec_i,
    .busy_o(busy), .verb_valid_o, .rsp_take_o(rsp_take)
  );

  assign verb_data_o = cmd;

  // R5: busy falls only together with valid
  a_r5_busy_valid_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> valid);
  // R6: nothing outstanding, nothing latched
  a_r6_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy) |-> !$rose(valid));
  // R3: offered verb does not change
  a_r3_verb_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verb_valid_o && !verb_ready_i) |=> $stable(verb_data_o));
endmodule

// File: tb/imm_cmd_if_tb.sv
module imm_cmd_if_tb;
  localparam int DW = 32;
  localparam int CW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_wr_i = 1'b0;
  logic [1:0]    reg_addr_i = '0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic [DW-1:0] reg_rdata_o;
  logic          verb_valid_o;
  logic          verb_ready_i = 1'b0;
  logic [DW-1:0] verb_data_o;
  logic          rsp_valid_i = 1'b0;
  logic [CW-1:0] rsp_codec_i = '0;
  logic [DW-1:0] rsp_data_i = '0;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] rv;

  always #4 clk_i = ~clk_i;

  imm_cmd_if u_dut (.*);

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic rsp(logic [CW-1:0] c, logic [DW-1:0] d);
    @(negedge clk_i);
    rsp_valid_i = 1'b1; rsp_codec_i = c; rsp_data_i = d;
    @(negedge clk_i);
    rsp_valid_i = 1'b0;
  endtask

  // monitor: every accepted verb must match the scoreboard head
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (rst_ni && verb_valid_o && verb_ready_i) begin
        if (exp_q.size() == 0) chk("R4 unexpected verb", verb_data_o, 32'hxxxx_xxxx);
        else chk("R4 verb on link", verb_data_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    rd(2, rv); chk("R1 status", rv, 0);
    rd(1, rv); chk("R1 response", rv, 0);
    chk("R1 verb_valid", {31'b0, verb_valid_o}, 0);

    wr(0, 32'h20F0_0011); exp_q.push_back(32'h20F0_0011);
    rd(0, rv); chk("R2 command readback", rv, 32'h20F0_0011);
    wr(2, 32'h1);
    #1;
    rd(2, rv); chk("R4 busy set", rv, 32'h1);
    chk("R4 verb_valid up", {31'b0, verb_valid_o}, 1);
    chk("R4 verb data", verb_data_o, 32'h20F0_0011);
    repeat (3) @(negedge clk_i);
    #1;
    chk("R4 verb held", {31'b0, verb_valid_o}, 1);
    wr(0, 32'hDEAD_BEEF);
    rd(0, rv); chk("R3 command ignored", rv, 32'h20F0_0011);
    chk("R3 verb data unchanged", verb_data_o, 32'h20F0_0011);
    wr(2, 32'h0);
    rd(2, rv); chk("R9 busy kept", rv, 32'h1);
    rsp(4'h2, 32'h1111_1111);
    rd(2, rv); chk("R6 early response dropped", rv, 32'h1);
    rd(1, rv); chk("R6 early response not latched", rv, 0);
    @(negedge clk_i); verb_ready_i = 1'b1;
    @(negedge clk_i); verb_ready_i = 1'b0;
    #1;
    chk("R4 verb_valid drops", {31'b0, verb_valid_o}, 0);
    rsp(4'h5, 32'h2222_2222);
    rd(2, rv); chk("R6 wrong codec dropped", rv, 32'h1);
    rsp(4'h2, 32'h0000_ABCD);
    rd(2, rv); chk("R5 valid set busy clear", rv, 32'h2);
    rd(1, rv); chk("R5 response latched", rv, 32'h0000_ABCD);

    wr(2, 32'h0);
    rd(2, rv); chk("R7 write zero keeps valid", rv, 32'h2);
    wr(2, 32'h2);
    rd(2, rv); chk("R7 write one clears valid", rv, 32'h0);
    rsp(4'h2, 32'h3333_3333);
    rd(2, rv); chk("R6 idle response dropped", rv, 32'h0);
    rd(1, rv); chk("R6 idle response not latched", rv, 32'h0000_ABCD);

    verb_ready_i = 1'b1;
    wr(0, 32'hF000_1234); exp_q.push_back(32'hF000_1234);
    wr(2, 32'h1);
    rsp(4'hF, 32'h5555_AAAA);
    rd(2, rv); chk("R5 codec 15 response", rv, 32'h2);
    rd(1, rv); chk("R5 codec 15 data", rv, 32'h5555_AAAA);

    wr(0, 32'h3000_0001); exp_q.push_back(32'h3000_0001);
    wr(2, 32'h1);
    @(negedge clk_i);
    rsp_valid_i = 1'b1; rsp_codec_i = 4'h3; rsp_data_i = 32'h0000_0077;
    reg_wr_i = 1'b1; reg_addr_i = 2; reg_wdata_i = 32'h2;
    @(negedge clk_i);
    rsp_valid_i = 1'b0; reg_wr_i = 1'b0;
    rd(2, rv); chk("R8 response beats clear", rv, 32'h2);
    rd(1, rv); chk("R8 response data", rv, 32'h0000_0077);
    verb_ready_i = 1'b0;

    repeat (2) @(negedge clk_i);
    chk("R4 all verbs sent", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule